// File: doc/BRIEF.md
# UART receive status flag controller

This block keeps the receive-side status flags of a serial port, together with the one-entry buffer that holds the last received character. A separate receiver core hands it one result per character: the data byte plus noise, framing and parity indications. The core also gives it a pulse whenever the line has gone quiet. The CPU side supplies two read strobes, one for the status register and one for the data register. The block holds six flags: receive-buffer-full, idle line, overrun, noise, framing error and parity error.

Software clears flags with a two-step sequence. It reads the status register, then reads the data register. Only the flags that were set at the status read are cleared, and any new event in between spoils the sequence. A character that arrives while the buffer is still full is dropped, and it is reported through the overrun flag and a one-cycle lost indication. The idle flag can fire only once for each character accepted into the buffer.

The clear sequence is a two-state machine. State SEQ_DISARMED moves to SEQ_ARMED on a status read (transition ARM) and captures the flags that are set. From SEQ_ARMED, a status read re-captures and stays (REARM). A data read clears the captured flags and returns to SEQ_DISARMED (CLEAR). A flag newly set while no read occurs returns to SEQ_DISARMED without clearing (CANCEL). Otherwise the state holds (HOLD).

Top module: `uart_rx_flag_ctrl`

## Requirements
- R1: After reset, status_o reads 0x00, data_o reads 0 and char_lost_o is 0. Bits 7:6 of status_o always read 0.
- R2: A character is accepted while bit 5 (buffer full) is clear. On the next clock, bit 5 is set, data_o holds the byte, and bits 2 (noise), 1 (framing) and 0 (parity) are set exactly where the character's indications were 1.
- R3: A status read followed later by a data read clears every flag that was set at the status read. The cleared flags read 0 on the clock after the data read.
- R4: A data read with no armed status read before it leaves status_o and data_o unchanged.
- R5: A flag that newly sets after a status read and before the next data read cancels the arming. The following data read then changes nothing.
- R6: A character that arrives while bit 5 is set, and is not being cleared in that cycle, is discarded. char_lost_o is 1 in that cycle, and on the next clock bit 3 (overrun) is set. data_o and bits 2:0 stay unchanged.
- R7: A line-idle pulse sets bit 4 (idle) only if a character has been accepted since the previous idle flag, or since reset. It sets only once, however long line_idle stays high.
- R8: A character that arrives in the same cycle as a clearing data read that frees the buffer is accepted, not lost. Flags set by that character stay set.
- R9: A status read and a data read in the same cycle count as a status read only. No flag is cleared in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_valid | input | 1 | One-cycle pulse: a character is ready from the receiver core |
| char_data | input | 8 | Received byte |
| char_noise | input | 1 | Noise seen while receiving the character |
| char_frame | input | 1 | Stop bit was low |
| char_parity | input | 1 | Parity mismatch |
| line_idle | input | 1 | Receiver sees an idle line |
| status_rd | input | 1 | CPU reads the status register this cycle |
| data_rd | input | 1 | CPU reads the data register this cycle |
| status_o | output | 8 | Bit 5 full, 4 idle, 3 overrun, 2 noise, 1 framing, 0 parity |
| data_o | output | 8 | Receive buffer contents |
| char_lost_o | output | 1 | A character is being discarded this cycle |

## Verification
The assertions check four things on every cycle:
- no flag ever falls except on the clock after a data read;
- an error bit never rises without the full bit;
- a lost character always leaves the buffer untouched and the overrun flag set;
- the idle flag never rises twice without an accepted character in between.

Only the bench scenarios can show the rest. These are the exact cleared set after a sequence, the cancelled sequence, the ignored out-of-order read, same-cycle accept during a clear, and the priority of simultaneous reads. They also include the full sweep of error combinations and data bytes.

// File: rtl/uart_rxflag_pkg.sv
package uart_rxflag_pkg;
    localparam int FLAG_W = 6;
    localparam int B_PAR  = 0;
    localparam int B_FRM  = 1;
    localparam int B_NSE  = 2;
    localparam int B_OVR  = 3;
    localparam int B_IDL  = 4;
    localparam int B_FUL  = 5;

    typedef enum logic [0:0] {
        SEQ_DISARMED = 1'b0,
        SEQ_ARMED    = 1'b1
    } seq_state_e;
endpackage

// File: rtl/rx_clear_seq.sv
module rx_clear_seq
    import uart_rxflag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              status_rd,
    input  logic              data_rd,
    input  logic              new_set,
    input  logic [FLAG_W-1:0] flags,
    output logic [FLAG_W-1:0] clr_vec
);
    seq_state_e        state_q, state_d;
    logic [FLAG_W-1:0] snap_q;

    // next-state logic: ARM, REARM, CLEAR, CANCEL, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_DISARMED: if (status_rd) state_d = SEQ_ARMED;
            SEQ_ARMED: begin
                if (status_rd)    state_d = SEQ_ARMED;
                else if (data_rd) state_d = SEQ_DISARMED;
                else if (new_set) state_d = SEQ_DISARMED;
                else              state_d = SEQ_ARMED;
            end
            default: state_d = SEQ_DISARMED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_DISARMED;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            if (status_rd) snap_q <= flags;
        end
    end

    // output: clear mask is active only on the CLEAR transition (R9: status read wins)
    always_comb begin
        clr_vec = '0;
        unique case (state_q)
            SEQ_ARMED:    if (data_rd && !status_rd) clr_vec = snap_q;
            SEQ_DISARMED: clr_vec = '0;
            default:      clr_vec = '0;
        endcase
    end
endmodule

// File: rtl/rx_idle_gate.sv
module rx_idle_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic line_idle,
    input  logic idle_flag,
    output logic fire
);
    logic allow_q;

    assign fire = line_idle && allow_q && !idle_flag;

    always_ff @(posedge clk) begin
        if (!rst_n)      allow_q <= 1'b0;
        else if (accept) allow_q <= 1'b1;
        else if (fire)   allow_q <= 1'b0;
    end
endmodule

// File: rtl/rx_data_slot.sv
module rx_data_slot #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DATA_W-1:0] char_data,
    output logic [DATA_W-1:0] data_q
);
    always_ff @(posedge clk) begin
        if (!rst_n)      data_q <= '0;
        else if (accept) data_q <= char_data;
    end
endmodule

// File: rtl/uart_rx_flag_ctrl.sv
module uart_rx_flag_ctrl
    import uart_rxflag_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_valid,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_noise,
    input  logic              char_frame,
    input  logic              char_parity,
    input  logic              line_idle,
    input  logic              status_rd,
    input  logic              data_rd,
    output logic [STAT_W-1:0] status_o,
    output logic [DATA_W-1:0] data_o,
    output logic              char_lost_o
);
    localparam int PAD_W = STAT_W - FLAG_W;

    logic [FLAG_W-1:0] flags_q, set_vec, clr_vec;
    logic              accept, idle_fire, new_set;

    // R8: a buffer freed in this cycle takes the incoming character
    assign accept      = char_valid && (!flags_q[B_FUL] || clr_vec[B_FUL]);
    assign char_lost_o = char_valid && !accept;

    always_comb begin
        set_vec        = '0;
        set_vec[B_FUL] = accept;
        set_vec[B_NSE] = accept && char_noise;
        set_vec[B_FRM] = accept && char_frame;
        set_vec[B_PAR] = accept && char_parity;
        set_vec[B_OVR] = char_lost_o;
        set_vec[B_IDL] = idle_fire;
    end

    assign new_set = |(set_vec & ~flags_q);

    rx_clear_seq i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_rd(status_rd),
        .data_rd  (data_rd),
        .new_set  (new_set),
        .flags    (flags_q),
        .clr_vec  (clr_vec)
    );

    rx_idle_gate i_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .line_idle(line_idle),
        .idle_flag(flags_q[B_IDL]),
        .fire     (idle_fire)
    );

    rx_data_slot #(.DATA_W(DATA_W)) i_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .char_data(char_data),
        .data_q   (data_o)
    );

    // new events take precedence over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_vec) | set_vec;
    end

    assign status_o = {{PAD_W{1'b0}}, flags_q};
endmodule

// File: rtl/uart_rx_flag_chk.sv
module uart_rx_flag_chk #(
    parameter int DATA_W = 8,
    parameter int STAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              char_valid,
    input logic              data_rd,
    input logic [STAT_W-1:0] status_o,
    input logic [DATA_W-1:0] data_o,
    input logic              char_lost_o
);
    logic past_ok, got_char, idle_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok   <= 1'b0;
            got_char  <= 1'b0;
            idle_prev <= 1'b0;
        end else begin
            past_ok   <= 1'b1;
            idle_prev <= status_o[4];
            if (char_valid && !char_lost_o)     got_char <= 1'b1;
            else if (status_o[4] && !idle_prev) got_char <= 1'b0;
        end
    end

    AST_FALL_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (($past(status_o[5:0]) & ~status_o[5:0]) != 6'd0)) |-> $past(data_rd)); // R4
    AST_ERR_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && ($rose(status_o[2]) || $rose(status_o[1]) || $rose(status_o[0]))) |-> status_o[5]); // R2
    AST_LOST_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        char_lost_o |-> status_o[5]); // R6
    AST_LOST_SETS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
        char_lost_o |=> status_o[3]); // R6
    AST_LOST_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        char_lost_o |=> $stable(data_o)); // R6
    AST_IDLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $rose(status_o[4])) |-> $past(got_char)); // R7
endmodule

bind uart_rx_flag_ctrl uart_rx_flag_chk #(.DATA_W(DATA_W), .STAT_W(STAT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .char_valid (char_valid),
    .data_rd    (data_rd),
    .status_o   (status_o),
    .data_o     (data_o),
    .char_lost_o(char_lost_o)
);

// File: tb/test_uart_rx_flag_ctrl.sv
`timescale 1ns/1ps
module test_uart_rx_flag_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       char_valid = 1'b0;
    logic [7:0] char_data = '0;
    logic       char_noise = 1'b0, char_frame = 1'b0, char_parity = 1'b0;
    logic       line_idle = 1'b0, status_rd = 1'b0, data_rd = 1'b0;
    logic [7:0] status_o, data_o;
    logic       char_lost_o;
    logic       lost_seen;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_rx_flag_ctrl i_uart_rx_flag_ctrl (
        .clk(clk), .rst_n(rst_n), .char_valid(char_valid), .char_data(char_data),
        .char_noise(char_noise), .char_frame(char_frame), .char_parity(char_parity),
        .line_idle(line_idle), .status_rd(status_rd), .data_rd(data_rd),
        .status_o(status_o), .data_o(data_o), .char_lost_o(char_lost_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic [2:0] e);
        @(negedge clk);
        char_valid = 1'b1; char_data = d;
        {char_noise, char_frame, char_parity} = e;
        #1 lost_seen = char_lost_o;
        @(negedge clk);
        char_valid = 1'b0; {char_noise, char_frame, char_parity} = 3'b000;
    endtask

    task automatic rd(input logic s, input logic d);
        @(negedge clk);
        status_rd = s; data_rd = d;
        @(negedge clk);
        status_rd = 1'b0; data_rd = 1'b0;
    endtask

    task automatic pulse_idle;
        @(negedge clk); line_idle = 1'b1;
        @(negedge clk); line_idle = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 status", status_o, 8'h00);
        chk("R1 data", data_o, 8'h00);
        chk("R1 lost", {7'd0, char_lost_o}, 8'h00);
        rst_n = 1'b1;

        // R7: idle before any character does not set
        pulse_idle();
        chk("R7 no idle before char", status_o, 8'h00);

        // R2/R3 sweep over error combinations
        for (int e = 0; e < 8; e++) begin
            send(8'h90 + 8'(e), 3'(e));
            chk("R2 status", status_o, 8'h20 | 8'(e));
            chk("R2 data", data_o, 8'h90 + 8'(e));
            rd(1'b1, 1'b0);
            chk("R3 status read keeps", status_o, 8'h20 | 8'(e));
            rd(1'b0, 1'b1);
            chk("R3 cleared", status_o, 8'h00);
        end
        // R2 data sweep
        for (int d = 0; d < 256; d++) begin
            send(8'(d), 3'b000);
            chk("R2 byte", data_o, 8'(d));
            rd(1'b1, 1'b0);
            rd(1'b0, 1'b1);
            chk("R3 byte clear", status_o, 8'h00);
        end

        // R7: one-shot idle
        pulse_idle();
        chk("R7 idle after char", status_o, 8'h10);
        rd(1'b1, 1'b0); rd(1'b0, 1'b1);
        chk("R3 idle cleared", status_o, 8'h00);
        pulse_idle();
        chk("R7 idle no reset without char", status_o, 8'h00);
        send(8'h3C, 3'b000);
        @(negedge clk); line_idle = 1'b1;
        repeat (6) @(negedge clk);
        chk("R7 long idle", status_o, 8'h30);
        rd(1'b1, 1'b0); rd(1'b0, 1'b1);
        repeat (4) @(negedge clk);
        chk("R7 held idle no repeat", status_o, 8'h00);
        line_idle = 1'b0;

        // R6 overrun
        send(8'hA1, 3'b000);
        send(8'hB2, 3'b110);
        chk("R6 lost pulse", {7'd0, lost_seen}, 8'h01);
        chk("R6 status", status_o, 8'h28);
        chk("R6 data kept", data_o, 8'hA1);
        rd(1'b1, 1'b0); rd(1'b0, 1'b1);
        chk("R6 clear", status_o, 8'h00);

        // R4 out-of-order
        send(8'h55, 3'b010);
        rd(1'b0, 1'b1);
        chk("R4 bare data read", status_o, 8'h22);
        chk("R4 data", data_o, 8'h55);
        rd(1'b1, 1'b0);
        rd(1'b0, 1'b1);
        chk("R4 then proper clear", status_o, 8'h00);

        // R5 cancel
        rd(1'b1, 1'b0);
        send(8'h66, 3'b001);
        rd(1'b0, 1'b1);
        chk("R5 cancelled", status_o, 8'h21);
        rd(1'b1, 1'b0);
        pulse_idle();
        rd(1'b0, 1'b1);
        chk("R5 idle cancels", status_o, 8'h31);
        rd(1'b1, 1'b0); rd(1'b0, 1'b1);
        chk("R5 clear", status_o, 8'h00);

        // R9 simultaneous reads
        send(8'h77, 3'b000);
        rd(1'b1, 1'b1);
        chk("R9 no clear", status_o, 8'h20);
        rd(1'b0, 1'b1);
        chk("R9 later data read clears", status_o, 8'h00);

        // R8 accept during clearing read
        send(8'h11, 3'b000);
        rd(1'b1, 1'b0);
        @(negedge clk);
        data_rd = 1'b1; char_valid = 1'b1; char_data = 8'h22; char_frame = 1'b1;
        #1 lost_seen = char_lost_o;
        @(negedge clk);
        data_rd = 1'b0; char_valid = 1'b0; char_frame = 1'b0;
        chk("R8 not lost", {7'd0, lost_seen}, 8'h00);
        chk("R8 status", status_o, 8'h22);
        chk("R8 data", data_o, 8'h22);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule